// File: doc/BRIEF.md
# Two-Pole Two-Zero Loop Compensator

This block computes the control law of a voltage-mode power-converter loop in fixed point. On each sample strobe it takes an unsigned reference word and an unsigned feedback word and forms a signed error. It then evaluates a second-order recursive difference equation over the current error, the two previous errors and the two previous outputs. The result is limited to a programmable window and converted into a PWM compare value.

A single signed multiplier with a wide accumulator is stepped through the five products of the law and is then reused for the duty scaling. A result appears a fixed number of clocks after the strobe, marked by a one-cycle valid pulse. Several coefficient sets are held at once. A select input picks the set at each strobe, so the loop can switch between tunings while it runs. A proportional-integral-derivative tuning is loaded as one such set, with the output-feedback weight at unity and the second one at zero.

Top module: `loop_comp_2p2z`

## Requirements
- R1: On an accepted strobe the error is e(n) = (ref_i − fdbk_i), taken as unsigned operands, signed-extended to 32 bits and shifted left by 8 (Q24).
- R2: u(n) = b0·e(n) + b1·e(n−1) + b2·e(n−2) + a1·u(n−1) + a2·u(n−2). Coefficients are signed Q26 and history is signed Q24. The sum is kept in a 64-bit accumulator, 2^25 is added, the total is shifted right arithmetically by 26 and the result is truncated to 32 bits.
- R3: A configuration write (cfg_we_i high at a clock edge) stores cfg_data_i into entry cfg_idx_i of set cfg_set_i. The index encoding is 0=b0, 1=b1, 2=b2, 3=a1, 4=a2, 5=upper limit, 6=lower limit, 7=duty scale.
- R4: ctrl_o is u(n) limited first against the upper limit and then raised to the lower limit, so the lower limit wins when the two limits cross.
- R5: duty_o is the low 16 bits of (ctrl_o · duty scale) shifted right arithmetically by 24.
- R6: After each computation the history shifts: e(n−2)←e(n−1), e(n−1)←e(n), u(n−2)←u(n−1), u(n−1)←u(n). The stored u(n) is the value before limiting.
- R7: valid_o pulses high for exactly one cycle, on the 7th rising edge after the edge that accepts the strobe. ctrl_o and duty_o update with that pulse and hold until the next one.
- R8: set_sel_i is sampled only at the accepting edge. Changing it during a computation has no effect on that computation's result.
- R9: A strobe that arrives while a computation is in progress is ignored. It produces no extra valid pulse and no change to the result.
- R10: clr_i high at a clock edge zeroes all four history registers. Clearing takes priority over the history shift.
- R11: After reset, valid_o, ctrl_o and duty_o are 0. Every set has all coefficients 0, lower limit 0, upper limit 2^24 (1.0 in Q24) and duty scale 65535.
- R12: A set with a1 = 67108864 (1.0 in Q26), a2 = 0, b0 = (P+I+D)·67108, b1 = (I−P−2D)·67108 and b2 = D·67108 behaves as a PID controller under the law of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous history clear |
| strobe_i | input | 1 | Sample strobe, starts a computation when idle |
| ref_i | input | 16 | Unsigned reference word |
| fdbk_i | input | 16 | Unsigned feedback word |
| set_sel_i | input | 2 | Coefficient set used by the next computation |
| cfg_we_i | input | 1 | Coefficient write enable |
| cfg_set_i | input | 2 | Set addressed by a write |
| cfg_idx_i | input | 3 | Entry addressed by a write (see R3) |
| cfg_data_i | input | 32 | Write data |
| valid_o | output | 1 | One-cycle result strobe |
| ctrl_o | output | 32 | Limited control word, signed Q24 |
| duty_o | output | 16 | PWM compare value |

## Verification
A corrupted history register does not show up in the result that produced it. It appears in ctrl_o one or two samples later, weighted by the coefficient it meets. For that reason the bench runs long strobe sequences with a full arithmetic model and uses sets with a unity output-feedback weight, which expose the stored u(n−1) directly at the next valid pulse. A fault in the sequencing or the set latch shows up as a valid pulse on the wrong edge, or as a result computed with the wrong set, within the same 8-cycle window. Rounding and limit faults are caught through chosen inputs that land exactly on half an LSB or on crossed limits.

// File: rtl/loop_comp_pkg.sv
package loop_comp_pkg;
  localparam int NCOEF = 8;
  localparam int IDX_W = 3;
  localparam int NTERM = 5;

  typedef enum logic [IDX_W-1:0] {
    IDX_B0    = 3'd0,
    IDX_B1    = 3'd1,
    IDX_B2    = 3'd2,
    IDX_A1    = 3'd3,
    IDX_A2    = 3'd4,
    IDX_HI    = 3'd5,
    IDX_LO    = 3'd6,
    IDX_SCALE = 3'd7
  } coef_idx_e;
endpackage

// File: rtl/lc_coef_bank.sv
module lc_coef_bank
  import loop_comp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NSETS  = 3,
  parameter int DUTY_W = 16,
  parameter int DATA_Q = 24,
  localparam int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [SET_W-1:0]              wr_set_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic [SET_W-1:0]              rd_set_i,
  output logic [NCOEF-1:0][DATA_W-1:0]  row_o
);
  localparam logic [DATA_W-1:0] HI_RST    = DATA_W'(1) << DATA_Q;
  localparam logic [DATA_W-1:0] SCALE_RST = (DATA_W'(1) << DUTY_W) - DATA_W'(1);

  logic [NCOEF-1:0][DATA_W-1:0] bank_q [NSETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NSETS; s++) begin
        for (int k = 0; k < NCOEF; k++) begin
          if (k == int'(IDX_HI))         bank_q[s][k] <= HI_RST;
          else if (k == int'(IDX_SCALE)) bank_q[s][k] <= SCALE_RST;
          else                           bank_q[s][k] <= '0;
        end
      end
    end else if (we_i) begin
      for (int s = 0; s < NSETS; s++)
        if (int'(wr_set_i) == s) bank_q[s][wr_idx_i] <= wr_data_i;
    end
  end

  always_comb begin
    row_o = bank_q[0];
    for (int s = 1; s < NSETS; s++)
      if (int'(rd_set_i) == s) row_o = bank_q[s];
  end
endmodule

// File: rtl/lc_mac.sv
module lc_mac #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 64,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic signed [ACC_W-1:0]  prod_o,
  output logic signed [ACC_W-1:0]  acc_o
);
  logic signed [PROD_W-1:0] p_w;

  assign p_w    = a_i * b_i;
  assign prod_o = ACC_W'(p_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_o <= '0;
    else if (clr_i)  acc_o <= '0;
    else if (en_i)   acc_o <= acc_o + prod_o;
  end
endmodule

// File: rtl/lc_clamp.sv
module lc_clamp #(
  parameter int DATA_W = 32
) (
  input  logic signed [DATA_W-1:0] u_i,
  input  logic signed [DATA_W-1:0] hi_i,
  input  logic signed [DATA_W-1:0] lo_i,
  output logic signed [DATA_W-1:0] y_o
);
  logic signed [DATA_W-1:0] t_w;

  // upper bound first, lower bound last: lo wins on crossed limits
  assign t_w = (u_i > hi_i) ? hi_i : u_i;
  assign y_o = (t_w < lo_i) ? lo_i : t_w;
endmodule

// File: rtl/loop_comp_2p2z.sv
module loop_comp_2p2z
  import loop_comp_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int DATA_W    = 32,
  parameter int ACC_W     = 64,
  parameter int NSETS     = 3,
  parameter int DUTY_W    = 16,
  parameter int ERR_SHIFT = 8,
  parameter int COEF_Q    = 26,
  parameter int DATA_Q    = 24,
  localparam int SET_W    = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              strobe_i,
  input  logic [IN_W-1:0]   ref_i,
  input  logic [IN_W-1:0]   fdbk_i,
  input  logic [SET_W-1:0]  set_sel_i,
  input  logic              cfg_we_i,
  input  logic [SET_W-1:0]  cfg_set_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DUTY_W-1:0] duty_o
);
  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] STEP_ROUND = CNT_W'(NTERM);
  localparam logic [CNT_W-1:0] STEP_DUTY  = CNT_W'(NTERM + 1);
  localparam logic signed [ACC_W-1:0] RND = ACC_W'(1) <<< (COEF_Q - 1);

  logic                     busy_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [SET_W-1:0]         set_q;
  logic signed [DATA_W-1:0] en_q, e1_q, e2_q, u1_q, u2_q, usat_q;
  logic [NCOEF-1:0][DATA_W-1:0] row_w;

  logic signed [IN_W:0]     diff_w;
  logic signed [DATA_W-1:0] err_w, mul_a, mul_b, u_w, sat_w;
  logic signed [ACC_W-1:0]  prod_w, acc_w, rnd_w;
  logic                     accept_w, mac_en_w;

  assign accept_w = strobe_i && !busy_q;
  assign diff_w   = $signed({1'b0, ref_i}) - $signed({1'b0, fdbk_i});
  assign err_w    = DATA_W'(diff_w) <<< ERR_SHIFT;

  lc_coef_bank #(
    .DATA_W(DATA_W), .NSETS(NSETS), .DUTY_W(DUTY_W), .DATA_Q(DATA_Q)
  ) u_bank (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i),
    .wr_set_i  (cfg_set_i),
    .wr_idx_i  (cfg_idx_i),
    .wr_data_i (cfg_data_i),
    .rd_set_i  (set_q),
    .row_o     (row_w)
  );

  always_comb begin
    unique case (cnt_q)
      3'd0:    begin mul_a = $signed(row_w[IDX_B0]); mul_b = en_q; end
      3'd1:    begin mul_a = $signed(row_w[IDX_B1]); mul_b = e1_q; end
      3'd2:    begin mul_a = $signed(row_w[IDX_B2]); mul_b = e2_q; end
      3'd3:    begin mul_a = $signed(row_w[IDX_A1]); mul_b = u1_q; end
      3'd4:    begin mul_a = $signed(row_w[IDX_A2]); mul_b = u2_q; end
      default: begin mul_a = $signed(row_w[IDX_SCALE]); mul_b = usat_q; end
    endcase
  end

  assign mac_en_w = busy_q && (cnt_q < STEP_ROUND);

  lc_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
    .clk_i, .rst_ni,
    .clr_i  (accept_w),
    .en_i   (mac_en_w),
    .a_i    (mul_a),
    .b_i    (mul_b),
    .prod_o (prod_w),
    .acc_o  (acc_w)
  );

  assign rnd_w = acc_w + RND;
  assign u_w   = DATA_W'(rnd_w >>> COEF_Q);

  lc_clamp #(.DATA_W(DATA_W)) u_clamp (
    .u_i  (u_w),
    .hi_i ($signed(row_w[IDX_HI])),
    .lo_i ($signed(row_w[IDX_LO])),
    .y_o  (sat_w)
  );

  // sequencer: accept, 5 MAC steps, round/limit, duty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      set_q   <= '0;
      en_q    <= '0;
      usat_q  <= '0;
      valid_o <= 1'b0;
      ctrl_o  <= '0;
      duty_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (!busy_q) begin
        if (strobe_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          en_q   <= err_w;
          set_q  <= set_sel_i;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == STEP_ROUND) usat_q <= sat_w;
        if (cnt_q == STEP_DUTY) begin
          busy_q  <= 1'b0;
          valid_o <= 1'b1;
          ctrl_o  <= usat_q;
          duty_o  <= DUTY_W'(prod_w >>> DATA_Q);
        end
      end
    end
  end

  // history: unlimited u(n) is stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e1_q <= '0; e2_q <= '0; u1_q <= '0; u2_q <= '0;
    end else if (clr_i) begin
      e1_q <= '0; e2_q <= '0; u1_q <= '0; u2_q <= '0;
    end else if (busy_q && cnt_q == STEP_ROUND) begin
      e2_q <= e1_q;
      e1_q <= en_q;
      u2_q <= u1_q;
      u1_q <= u_w;
    end
  end
endmodule

// File: rtl/loop_comp_2p2z_chk.sv
module loop_comp_2p2z_chk #(
  parameter int DATA_W = 32,
  parameter int SET_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic              busy_i,
  input logic [SET_W-1:0]  set_i,
  input logic [DATA_W-1:0] en_i,
  input logic [DATA_W-1:0] e1_i,
  input logic [DATA_W-1:0] e2_i,
  input logic [DATA_W-1:0] u1_i,
  input logic [DATA_W-1:0] u2_i,
  input logic              valid_i
);
  assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  assert_valid_ends_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ($past(busy_i) && !busy_i));

  assert_set_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(set_i));

  assert_strobe_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(en_i));

  assert_clear_history_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (e1_i == '0 && e2_i == '0 && u1_i == '0 && u2_i == '0));

  assert_history_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !clr_i) |=> ($stable(e1_i) && $stable(e2_i) && $stable(u1_i) && $stable(u2_i)));
endmodule

bind loop_comp_2p2z loop_comp_2p2z_chk #(.DATA_W(DATA_W), .SET_W(SET_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_i   (clr_i),
  .busy_i  (busy_q),
  .set_i   (set_q),
  .en_i    (en_q),
  .e1_i    (e1_q),
  .e2_i    (e2_q),
  .u1_i    (u1_q),
  .u2_i    (u2_q),
  .valid_i (valid_o)
);

// File: tb/tb_loop_comp_2p2z.sv
module tb_loop_comp_2p2z;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic        strobe_i = 1'b0;
  logic [15:0] ref_i = '0;
  logic [15:0] fdbk_i = '0;
  logic [1:0]  set_sel_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_set_i = '0;
  logic [2:0]  cfg_idx_i = '0;
  logic [31:0] cfg_data_i = '0;
  logic        valid_o;
  logic [31:0] ctrl_o;
  logic [15:0] duty_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  longint cf[3][8];
  longint me1 = 0, me2 = 0, mu1 = 0, mu2 = 0;
  longint last_sat, last_duty;
  int unsigned lcg = 32'h1234_5678;

  always #5 clk = ~clk;

  loop_comp_2p2z dut (
    .clk_i(clk), .rst_ni, .clr_i, .strobe_i, .ref_i, .fdbk_i, .set_sel_i,
    .cfg_we_i, .cfg_set_i, .cfg_idx_i, .cfg_data_i, .valid_o, .ctrl_o, .duty_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int unsigned nxt();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg >> 8;
  endfunction

  task automatic wr(input int s, input int idx, input longint v);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_set_i = 2'(s); cfg_idx_i = 3'(idx); cfg_data_i = v[31:0];
    @(negedge clk);
    cfg_we_i = 1'b0;
    cf[s][idx] = longint'(int'(v[31:0]));
  endtask

  task automatic clear_hist();
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
    me1 = 0; me2 = 0; mu1 = 0; mu2 = 0;
  endtask

  // model of R1, R2, R4, R5, R6
  function automatic void model(input int r, input int f, input int s);
    longint e, acc, u, t;
    e   = longint'((r - f) * 256);
    acc = cf[s][0]*e + cf[s][1]*me1 + cf[s][2]*me2 + cf[s][3]*mu1 + cf[s][4]*mu2;
    u   = longint'(int'((acc + (64'sd1 <<< 25)) >>> 26));
    t   = (u > cf[s][5]) ? cf[s][5] : u;
    last_sat  = (t < cf[s][6]) ? cf[s][6] : t;
    last_duty = ((last_sat * cf[s][7]) >>> 24) & 64'hFFFF;
    me2 = me1; me1 = e; mu2 = mu1; mu1 = u;
  endfunction

  // mode 0 plain, 1 set_sel changed mid-run (R8), 2 extra strobe mid-run (R9)
  task automatic sample(input int r, input int f, input int s, input int mode, input string req);
    bit early;
    @(negedge clk);
    ref_i = 16'(r); fdbk_i = 16'(f); set_sel_i = 2'(s); strobe_i = 1'b1;
    early = 0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k == 1) begin
        strobe_i = 1'b0;
        if (mode == 1) set_sel_i = 2'((s + 1) % 3);
        ref_i = 16'(r + 77);
      end
      if (mode == 2 && k == 3) strobe_i = 1'b1;
      if (mode == 2 && k == 4) strobe_i = 1'b0;
      if (valid_o) early = 1;
    end
    chk(!early, "R7 no early valid", longint'(early), 0);
    @(negedge clk);
    model(r, f, s);
    chk(valid_o == 1'b1, "R7 valid on 7th edge", longint'(valid_o), 1);
    chk(longint'(int'(ctrl_o)) == last_sat, req, longint'(int'(ctrl_o)), last_sat);
    chk(longint'(duty_o) == last_duty, {req, " duty R5"}, longint'(duty_o), last_duty);
    @(negedge clk);
    chk(valid_o == 1'b0, "R7 single pulse", longint'(valid_o), 0);
    if (mode == 2) begin
      early = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (valid_o) early = 1;
      end
      chk(!early, "R9 stray strobe ignored", longint'(early), 0);
      chk(longint'(int'(ctrl_o)) == last_sat, "R9 result held", longint'(int'(ctrl_o)), last_sat);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 3; s++)
      for (int k = 0; k < 8; k++)
        cf[s][k] = (k == 5) ? (64'sd1 <<< 24) : (k == 7) ? 64'sd65535 : 64'sd0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(valid_o == 1'b0, "R11 valid reset", longint'(valid_o), 0);
    chk(ctrl_o == 32'd0, "R11 ctrl reset", longint'(ctrl_o), 0);
    chk(duty_o == 16'd0, "R11 duty reset", longint'(duty_o), 0);

    // R11 default limits/scale, R1/R2 unity gain, R3 index 0
    wr(0, 0, 64'sd1 <<< 26);
    sample(1000, 0, 0, 0, "R11 default limits R1");
    chk(longint'(duty_o) == 999, "R5 unity duty", longint'(duty_o), 999);
    sample(0, 1000, 0, 0, "R4 default low limit");
    chk(ctrl_o == 32'd0, "R4 negative floored", longint'(int'(ctrl_o)), 0);
    sample(65535, 0, 0, 0, "R1 full-scale error");

    // R2 rounding at half LSB
    clear_hist();
    wr(0, 0, 64'sd1 <<< 17);
    sample(1, 0, 0, 0, "R2 round half up positive");
    chk(ctrl_o == 32'd1, "R2 +0.5 -> 1", longint'(int'(ctrl_o)), 1);
    wr(0, 5, 64'sd1 <<< 24); wr(0, 6, -(64'sd1 <<< 24));
    sample(0, 1, 0, 0, "R2 round half up negative");
    chk(ctrl_o == 32'd0, "R2 -0.5 -> 0", longint'(int'(ctrl_o)), 0);
    sample(3, 0, 0, 0, "R2 round 1.5");
    chk(ctrl_o == 32'd2, "R2 1.5 -> 2", longint'(int'(ctrl_o)), 2);
    wr(0, 6, 0);

    // R12 PID set, R3 all indices
    wr(1, 0, (200 + 20 + 50) * 67108);
    wr(1, 1, (20 - 200 - 100) * 67108);
    wr(1, 2, 50 * 67108);
    wr(1, 3, 67108864);
    wr(1, 4, 0);
    wr(1, 5, 15099494);
    wr(1, 6, 64'sd1 <<< 20);
    wr(1, 7, 1000);
    // general 2P2Z set
    wr(2, 0, 64'sd1 <<< 26);
    wr(2, 1, -(64'sd3 <<< 24));
    wr(2, 2, 64'sd1 <<< 23);
    wr(2, 3, 40265318);
    wr(2, 4, 13421773);
    wr(2, 5, 64'sd12 <<< 20);
    wr(2, 6, 64'sd0);
    wr(2, 7, 40000);

    clear_hist();
    for (int i = 0; i < 60; i++)
      sample(2000, int'(nxt() % 4096), 1, 0, "R12 PID sweep R2 R6");
    clear_hist();
    for (int i = 0; i < 60; i++)
      sample(int'(nxt() % 4096), int'(nxt() % 4096), 2, 0, "R2 2p2z sweep R6");
    for (int i = 0; i < 30; i++)
      sample(int'(nxt() % 4096), int'(nxt() % 4096), int'(nxt() % 3), 0, "R3 set switching R2");

    // R8 mid-run set change, R9 stray strobe
    sample(1500, 900, 1, 1, "R8 set latched at strobe");
    sample(1200, 1500, 2, 1, "R8 set latched at strobe");
    sample(3000, 100, 1, 2, "R9 strobe during run");
    sample(100, 3000, 2, 2, "R9 strobe during run");

    // R4 crossed limits: lo wins
    clear_hist();
    wr(0, 0, 64'sd1 <<< 26); wr(0, 5, 1000); wr(0, 6, 2000);
    sample(500, 0, 0, 0, "R4 crossed limits");
    chk(ctrl_o == 32'd2000, "R4 lo wins", longint'(int'(ctrl_o)), 2000);

    // R6 unlimited history
    clear_hist();
    wr(0, 6, 0);
    sample(100, 0, 0, 0, "R6 limited output");
    chk(ctrl_o == 32'd1000, "R6 output at hi", longint'(int'(ctrl_o)), 1000);
    wr(0, 0, 0); wr(0, 3, 64'sd1 <<< 26); wr(0, 5, 64'sd1 <<< 24);
    sample(7, 7, 0, 0, "R6 history holds raw u");
    chk(ctrl_o == 32'd25600, "R6 raw u recalled", longint'(int'(ctrl_o)), 25600);

    // R10 clear
    clear_hist();
    sample(7, 7, 0, 0, "R10 history cleared");
    chk(ctrl_o == 32'd0, "R10 u1 zero", longint'(int'(ctrl_o)), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule